// File: doc/BRIEF.md
# Seconds Countdown Alarm

This block is a relative alarm timer. Software loads a count of seconds into it, turns counting on, and from then on every one-second tick from outside takes one off the count. When a tick brings the count from one to zero, the block latches a pending flag. That flag can drive an interrupt line, a wake-up line, or both, and software clears it by writing a one to the status register.

All registers are written through one simple write port. Reads are combinational from the same address bus. Every control register uses bit 0 only and reads back zero in its upper bits. To re-arm the alarm, software turns counting off, zeroes the count, waits, loads the new count and turns counting back on. The block places no restriction on that order.

Top module: `countdown_alarm`

## Requirements
- R1: After reset the count, the count enable, the interrupt enable, the wake enable and the pending flag are all zero, and both irqOut and wakeOut are low.
- R2: A write to byte offset 0x20 loads the full 32-bit count. It reads back at 0x20 from the next cycle on.
- R3: While the count enable (offset 0x28, bit 0) is 1 and the count is nonzero, each cycle with tick high lowers the count by exactly one, including from 0xFFFFFFFF. Only bit 0 of a write to 0x28 is stored.
- R4: While the count enable is 0, tick has no effect on the count.
- R5: A tick that takes the count from 1 to 0 sets the pending flag (offset 0x30, bit 0). With the count already at zero, further ticks neither change the count nor set the flag again.
- R6: Writing 0 to the count does not set the pending flag.
- R7: Writing 1 to bit 0 of offset 0x30 clears the pending flag. Writing 0 there leaves it unchanged.
- R8: If the count reaches zero in the same cycle as a clear write to 0x30, the flag ends up set.
- R9: irqOut is high exactly when the flag is set and the interrupt enable (offset 0x2C, bit 0) is 1.
- R10: wakeOut is high exactly when the flag is set and the wake enable (offset 0x50, bit 0) is 1.
- R11: A count write in the same cycle as an enabled tick loads the written value, with no decrement.
- R12: Writes to addresses outside 0x20, 0x28, 0x2C, 0x30 and 0x50 change no register, and reads from those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse each second |
| wrEn | input | 1 | Register write strobe |
| addr | input | 8 | Byte address for writes and reads |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data at addr |
| irqOut | output | 1 | Interrupt request |
| wakeOut | output | 1 | Wake-up request |

## Verification
A write or a tick presented before a rising edge changes its register at that edge. The new value therefore shows at rdData, irqOut and wakeOut in the same cycle, because all three are combinational from the registers. The bench drives each stimulus at a falling edge and withdraws it at the next falling edge, so exactly one rising edge sees it. It then samples one nanosecond after that second falling edge, once the single register stage has settled and before the next edge.

// File: rtl/alarm_pkg.sv
package alarm_pkg;

  // Byte offsets decoded by software
  localparam int OFF_COUNT  = 'h20;
  localparam int OFF_CNTEN  = 'h28;
  localparam int OFF_IRQEN  = 'h2C;
  localparam int OFF_STATUS = 'h30;
  localparam int OFF_WAKEEN = 'h50;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadCount;
    logic tickEn;
  } dpStrobe_t;

endpackage

// File: rtl/alarm_datapath.sv
module alarm_datapath
  import alarm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [CNT_W-1:0] loadValue,
  output logic [CNT_W-1:0] count,
  output logic             hitZero
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] countQ;
  logic             nonZero;
  logic             decNow;

  assign nonZero = |countQ;
  assign decNow  = strobe.tickEn && !strobe.loadCount && nonZero;
  assign hitZero = decNow && (countQ == ONE);
  assign count   = countQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (strobe.loadCount) begin
      countQ <= loadValue;
    end else if (decNow) begin
      countQ <= countQ - ONE;
    end
  end

  assert_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadCount |=> countQ == $past(loadValue));

  assert_dec_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tickEn && !strobe.loadCount && countQ != '0) |=> countQ == $past(countQ) - ONE);

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.tickEn && !strobe.loadCount) |=> $stable(countQ));

endmodule

// File: rtl/alarm_ctrl.sv
module alarm_ctrl
  import alarm_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrBit0,
  input  logic              hitZero,
  output dpStrobe_t         strobe,
  output logic              cntEn,
  output logic              irqEn,
  output logic              wakeEn,
  output logic              pending
);

  logic selCntEn, selIrqEn, selWakeEn, selStatus, statusClr;

  assign selCntEn  = wrEn && (addr == ADDR_W'(OFF_CNTEN));
  assign selIrqEn  = wrEn && (addr == ADDR_W'(OFF_IRQEN));
  assign selWakeEn = wrEn && (addr == ADDR_W'(OFF_WAKEEN));
  assign selStatus = wrEn && (addr == ADDR_W'(OFF_STATUS));
  assign statusClr = selStatus && wrBit0;

  assign strobe.loadCount = wrEn && (addr == ADDR_W'(OFF_COUNT));
  assign strobe.tickEn    = tick && cntEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntEn   <= 1'b0;
      irqEn   <= 1'b0;
      wakeEn  <= 1'b0;
      pending <= 1'b0;
    end else begin
      if (selCntEn)  cntEn  <= wrBit0;
      if (selIrqEn)  irqEn  <= wrBit0;
      if (selWakeEn) wakeEn <= wrBit0;
      if (hitZero) begin
        pending <= 1'b1;
      end else if (statusClr) begin
        pending <= 1'b0;
      end
    end
  end

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    hitZero |=> pending);

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (statusClr && !hitZero) |=> !pending);

  assert_only_on_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pending) |-> $past(hitZero));

endmodule

// File: rtl/countdown_alarm.sv
module countdown_alarm
  import alarm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut,
  output logic              wakeOut
);

  localparam logic [DATA_W-1:0] ZERO = '0;

  dpStrobe_t         strobe;
  logic [DATA_W-1:0] count;
  logic              hitZero, cntEn, irqEn, wakeEn, pending;

  alarm_datapath #(.CNT_W(DATA_W)) datapath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loadValue(wrData),
    .count(count), .hitZero(hitZero)
  );

  alarm_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .addr(addr),
    .wrBit0(wrData[0]), .hitZero(hitZero), .strobe(strobe),
    .cntEn(cntEn), .irqEn(irqEn), .wakeEn(wakeEn), .pending(pending)
  );

  always_comb begin
    rdData = ZERO;
    if      (addr == ADDR_W'(OFF_COUNT))  rdData = count;
    else if (addr == ADDR_W'(OFF_CNTEN))  rdData[0] = cntEn;
    else if (addr == ADDR_W'(OFF_IRQEN))  rdData[0] = irqEn;
    else if (addr == ADDR_W'(OFF_STATUS)) rdData[0] = pending;
    else if (addr == ADDR_W'(OFF_WAKEEN)) rdData[0] = wakeEn;
  end

  assign irqOut  = pending && irqEn;
  assign wakeOut = pending && wakeEn;

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |=> (!irqOut && !wakeOut));

endmodule

// File: tb/countdown_alarm_tb.sv
`timescale 1ns/1ps
module countdown_alarm_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irqOut, wakeOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  countdown_alarm dut_i (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irqOut(irqOut), .wakeOut(wakeOut)
  );

  // {req[3:0], op[1:0], addr[7:0], data[31:0]}; op 0 write, 1 tick, 2 read check
  localparam int NV = 29;
  localparam logic [45:0] VECS [0:NV-1] = '{
    {4'd2,  2'd0, 8'h20, 32'd3},          // R2 load
    {4'd2,  2'd2, 8'h20, 32'd3},
    {4'd4,  2'd1, 8'h00, 32'd0},          // R4 tick while disabled
    {4'd4,  2'd2, 8'h20, 32'd3},
    {4'd3,  2'd0, 8'h28, 32'd1},          // R3 enable
    {4'd3,  2'd2, 8'h28, 32'd1},
    {4'd3,  2'd1, 8'h00, 32'd0},
    {4'd3,  2'd2, 8'h20, 32'd2},
    {4'd3,  2'd1, 8'h00, 32'd0},
    {4'd3,  2'd2, 8'h20, 32'd1},
    {4'd5,  2'd2, 8'h30, 32'd0},          // R5 not yet pending
    {4'd5,  2'd1, 8'h00, 32'd0},
    {4'd5,  2'd2, 8'h20, 32'd0},
    {4'd5,  2'd2, 8'h30, 32'd1},
    {4'd7,  2'd0, 8'h30, 32'd0},          // R7 write 0 keeps flag
    {4'd7,  2'd2, 8'h30, 32'd1},
    {4'd7,  2'd0, 8'h30, 32'd1},          // R7 clear
    {4'd7,  2'd2, 8'h30, 32'd0},
    {4'd5,  2'd1, 8'h00, 32'd0},          // R5 no re-set at zero
    {4'd5,  2'd2, 8'h30, 32'd0},
    {4'd5,  2'd2, 8'h20, 32'd0},
    {4'd6,  2'd0, 8'h20, 32'd0},          // R6 write zero count
    {4'd6,  2'd2, 8'h30, 32'd0},
    {4'd3,  2'd0, 8'h28, 32'hFFFFFFFE},   // R3 only bit 0 stored
    {4'd3,  2'd2, 8'h28, 32'd0},
    {4'd12, 2'd0, 8'h40, 32'd5},          // R12 unmapped write
    {4'd12, 2'd2, 8'h40, 32'd0},
    {4'd12, 2'd2, 8'h20, 32'd0},
    {4'd12, 2'd2, 8'h28, 32'd0}
  };

  task automatic step(input logic w, input logic [7:0] a, input logic [31:0] d, input logic t);
    @(negedge clk);
    wrEn = w; addr = a; wrData = d; tick = t;
    @(negedge clk);
    wrEn = 1'b0; tick = 1'b0;
  endtask

  task automatic chk(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic readChk(input int req, input logic [7:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    chk(req, $sformatf("read @%h", a), rdData, exp);
  endtask

  task automatic pinChk(input int req, input logic expIrq, input logic expWake);
    #1;
    chk(req, "irqOut", {31'd0, irqOut}, {31'd0, expIrq});
    chk(req, "wakeOut", {31'd0, wakeOut}, {31'd0, expWake});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    readChk(1, 8'h20, 0); readChk(1, 8'h28, 0); readChk(1, 8'h2C, 0);
    readChk(1, 8'h30, 0); readChk(1, 8'h50, 0); pinChk(1, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      case (VECS[i][41:40])
        2'd0: step(1'b1, VECS[i][39:32], VECS[i][31:0], 1'b0);
        2'd1: step(1'b0, 8'h00, 32'd0, 1'b1);
        default: readChk(int'(VECS[i][45:42]), VECS[i][39:32], VECS[i][31:0]);
      endcase
    end

    // R9 / R10 masking
    step(1'b1, 8'h20, 32'd2, 1'b0);
    step(1'b1, 8'h28, 32'd1, 1'b0);
    step(1'b0, 8'h00, 32'd0, 1'b1);
    step(1'b0, 8'h00, 32'd0, 1'b1);
    readChk(5, 8'h30, 1);
    pinChk(9, 1'b0, 1'b0);
    step(1'b1, 8'h2C, 32'd1, 1'b0);
    pinChk(9, 1'b1, 1'b0);
    step(1'b1, 8'h50, 32'd1, 1'b0);
    pinChk(10, 1'b1, 1'b1);
    readChk(10, 8'h50, 1);
    step(1'b1, 8'h30, 32'd1, 1'b0);
    pinChk(9, 1'b0, 1'b0);

    // R8 set beats clear in the same cycle
    step(1'b1, 8'h20, 32'd1, 1'b0);
    step(1'b1, 8'h30, 32'd1, 1'b1);
    readChk(8, 8'h30, 1);
    pinChk(8, 1'b1, 1'b1);

    // R11 load wins over tick
    step(1'b1, 8'h20, 32'd10, 1'b0);
    step(1'b1, 8'h20, 32'd7, 1'b1);
    readChk(11, 8'h20, 7);
    step(1'b0, 8'h00, 32'd0, 1'b1);
    readChk(11, 8'h20, 6);

    // R3 decrement from full scale
    step(1'b1, 8'h20, 32'hFFFFFFFF, 1'b0);
    step(1'b0, 8'h00, 32'd0, 1'b1);
    readChk(3, 8'h20, 32'hFFFFFFFE);

    // R1 reset clears everything that is set now
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    readChk(1, 8'h20, 0); readChk(1, 8'h28, 0); readChk(1, 8'h30, 0);
    readChk(1, 8'h2C, 0); readChk(1, 8'h50, 0); pinChk(1, 1'b0, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule